// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor that completes every instruction in a single clock: the word at the program counter is fetched, decoded, executed and its result written back before the next rising edge. It supports five register-to-register operations, selected by the function code: add, subtract, AND, OR and signed set-on-less-than. It also supports a word load, a word store, a branch taken when two registers are equal, and an absolute jump. The datapath is steered by an opcode-driven control table. A second decode stage turns a two-bit operation class, together with the function field, into a four-bit ALU selector.

Instruction and data memories are small word arrays inside the block. While reset is held, a preload port fills either memory one word per clock. After reset is released, the core runs from byte address 0. It exposes its program counter, its register write-back port and its store port as outputs, so the surrounding logic can observe execution.

Top module: `occ_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and no register or memory write is signalled (`wb_en_o` and `st_en_o` stay 0).
- R2: Any instruction other than a taken branch or a jump advances the PC by 4. The PC always stays word-aligned.
- R3: With opcode 000000, funct 100000 writes rs+rt to rd, 100010 writes rs-rt, 100100 writes rs AND rt, 100101 writes rs OR rt, and 101010 writes 1 when rs < rt as signed values and 0 otherwise. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R4: With opcode 000000 and any other funct value, nothing is written and the PC advances by 4.
- R5: Opcode 100011 writes to rt the data word at word index ((rs + sign-extended imm[15:0]) >> 2) modulo the data depth.
- R6: Opcode 101011 stores rt at the same effective address and writes no register. At most one of register write and store is active in any cycle.
- R7: Opcode 000100 writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise the next PC is PC+4.
- R8: Opcode 000010 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R9: Register 0 always reads as zero. A write addressed to register 0 is reported on the write-back port but changes nothing.
- R10: Any opcode outside the five listed above writes nothing and advances the PC by 4.
- R11: A register or data-memory write made by one instruction is visible to the next instruction.
- R12: With `pre_we` high, `pre_sel`=0 writes `pre_data` to instruction word `pre_addr`. With `pre_sel`=1 it writes data word `pre_addr` modulo the data depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe |
| pre_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pre_addr | input | clog2(IMEM_DEPTH) | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write this cycle |
| wb_addr_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | Data store this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The testbench runs a generated program against an instruction-level model kept in the bench, and compares every port each cycle. The ALU operations are swept across operand pairs that include the signed extremes, all-ones, zero and equal operands. This separates signed from unsigned comparison and exposes carry and overflow mistakes in subtraction. Stores followed by loads with positive and negative offsets expose errors in effective-address and sign-extension logic. Forward, backward and untaken branches, jumps, unknown opcodes, undefined function codes and writes to register 0 each tell apart the next-PC sources and the write suppression paths.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_FUNCT = 2'b10;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  typedef struct packed {
    logic       dst_from_rd;
    logic       b_from_imm;
    logic       wb_from_mem;
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       is_branch;
    logic       is_jump;
    logic [1:0] op_class;
  } ctrl_t;
endpackage

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output logic [3:0] alu_sel,
  output logic       funct_ok
);
  // main decode: opcode -> datapath steering
  always_comb begin
    ctl = '0;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_from_rd = 1'b1;
        ctl.reg_wr      = 1'b1;
        ctl.op_class    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctl.b_from_imm  = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_wr      = 1'b1;
        ctl.mem_rd      = 1'b1;
        ctl.op_class    = CLS_ADD;
      end
      OPC_STORE: begin
        ctl.b_from_imm = 1'b1;
        ctl.mem_wr     = 1'b1;
        ctl.op_class   = CLS_ADD;
      end
      OPC_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.op_class  = CLS_SUB;
      end
      OPC_JUMP: ctl.is_jump = 1'b1;
      default: ctl = '0;
    endcase
  end

  // second-level decode: operation class + funct -> ALU selector
  always_comb begin
    funct_ok = 1'b1;
    alu_sel  = ALU_ADD;
    case (ctl.op_class)
      CLS_ADD: alu_sel = ALU_ADD;
      CLS_SUB: alu_sel = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  alu_sel = ALU_ADD;
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: funct_ok = 1'b0;
        endcase
      end
      default: alu_sel = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/occ_alu.sv
module occ_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  output logic [W-1:0] y,
  output logic         zero
);
  // sel[3]: invert a, sel[2]: invert b (and carry in), sel[1:0]: and/or/add/less
  logic [W-1:0] aa, bb, sum;
  logic         ovf, lt;

  always_comb begin
    aa  = sel[3] ? ~a : a;
    bb  = sel[2] ? ~b : b;
    sum = aa + bb + {{(W-1){1'b0}}, sel[2]};
    ovf = (aa[W-1] == bb[W-1]) && (sum[W-1] != aa[W-1]);
    lt  = sum[W-1] ^ ovf;
    case (sel[1:0])
      2'b00:   y = aa & bb;
      2'b01:   y = aa | bb;
      2'b10:   y = sum;
      default: y = {{(W-1){1'b0}}, lt};
    endcase
    zero = (y == '0);
  end
endmodule

// File: rtl/occ_regfile.sv
module occ_regfile #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);
  localparam int unsigned AW = $clog2(N);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != AW'(0)))
      regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];
endmodule

// File: rtl/occ_core.sv
module occ_core
  import occ_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 256,
  parameter int unsigned DMEM_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pre_we,
  input  logic                          pre_sel,
  input  logic [$clog2(IMEM_DEPTH)-1:0] pre_addr,
  input  logic [31:0]                   pre_data,
  output logic [31:0]                   pc_o,
  output logic                          wb_en_o,
  output logic [4:0]                    wb_addr_o,
  output logic [31:0]                   wb_data_o,
  output logic                          st_en_o,
  output logic [31:0]                   st_addr_o,
  output logic [31:0]                   st_data_o
);
  localparam int unsigned IAW = $clog2(IMEM_DEPTH);
  localparam int unsigned DAW = $clog2(DMEM_DEPTH);

  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr_w, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
  logic [3:0]      alu_sel;
  logic            alu_zero, funct_ok, reg_we, st_we;
  logic [4:0]      dst;
  ctrl_t           ctl;
  logic            unused_shamt;

  // preload and fetch
  always_ff @(posedge clk) begin
    if (pre_we && !pre_sel)
      imem[pre_addr] <= pre_data;
  end

  assign instr_w      = imem[pc_q[IAW+1:2]];
  assign unused_shamt = ^instr_w[10:6];

  occ_ctrl u_ctrl (
    .opcode   (instr_w[31:26]),
    .funct    (instr_w[5:0]),
    .ctl      (ctl),
    .alu_sel  (alu_sel),
    .funct_ok (funct_ok)
  );

  assign dst    = ctl.dst_from_rd ? instr_w[15:11] : instr_w[20:16];
  assign reg_we = ctl.reg_wr & funct_ok & ~rst;
  assign st_we  = ctl.mem_wr & ~rst;

  occ_regfile #(.W(XLEN), .N(32)) u_rf (
    .clk     (clk),
    .we      (reg_we),
    .waddr   (dst),
    .wdata   (wb_val),
    .raddr_a (instr_w[25:21]),
    .raddr_b (instr_w[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_sx = {{(XLEN-16){instr_w[15]}}, instr_w[15:0]};
  assign alu_b  = ctl.b_from_imm ? imm_sx : rt_val;

  occ_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: synchronous write, combinational read
  always_ff @(posedge clk) begin
    if (pre_we && pre_sel)
      dmem[pre_addr[DAW-1:0]] <= pre_data;
    else if (st_we)
      dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  assign ld_val = ctl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;
  assign wb_val = ctl.wb_from_mem ? ld_val : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr_w[25:0], 2'b00};

  always_comb begin
    if (ctl.is_jump)
      pc_next = jmp_tgt;
    else if (ctl.is_branch && alu_zero)
      pc_next = br_tgt;
    else
      pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = reg_we;
  assign wb_addr_o = dst;
  assign wb_data_o = wb_val;
  assign st_en_o   = st_we;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;
endmodule

// File: rtl/occ_core_chk.sv
module occ_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic        st_en
);
  logic [5:0] op;
  logic       op_known;
  assign op       = instr[31:26];
  assign op_known = (op == 6'b000000) || (op == 6'b100011) || (op == 6'b101011) ||
                    (op == 6'b000100) || (op == 6'b000010);

  p_quiet_reset_r1: assert property (@(posedge clk) rst |-> (!wb_en && !st_en));
  p_pc_cleared_r1:  assert property (@(posedge clk) rst |=> (pc == 32'd0));

  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000100 && op != 6'b000010) |=> (pc == $past(pc) + 32'd4));

  p_one_write_r6: assert property (@(posedge clk) disable iff (rst) $onehot0({wb_en, st_en}));

  p_beq_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000100) |-> (!wb_en && !st_en));

  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000010) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  p_nop_r10: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!wb_en && !st_en));
endmodule

bind occ_core occ_core_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .pc    (pc_o),
  .instr (instr_w),
  .wb_en (wb_en_o),
  .st_en (st_en_o)
);

// File: tb/occ_core_test.sv
`timescale 1ns/1ps
module occ_core_test;
  localparam int ID = 256;
  localparam int DD = 32;
  localparam int CYCLES = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0, pre_sel = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]  wb_addr_o;
  logic        wb_en_o, st_en_o;

  always #2 clk = ~clk;

  occ_core #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) uut (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_sel(pre_sel), .pre_addr(pre_addr),
    .pre_data(pre_data), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  int vecs = 0, fails = 0, n = 0;
  bit done = 0;
  logic [31:0] prog [ID];
  logic [31:0] dinit [DD];
  logic [31:0] mreg [32];
  logic [31:0] mdm [DD];
  logic [31:0] mpc;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (pc model %h)", tag, what, act, exp, mpc);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'b000010, 26'(idx)};
  endfunction
  task automatic emit(input logic [31:0] w);
    prog[n] = w;
    n++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] seed, ins, sx, a, b, res, addr, npc, exp_wd, exp_sa, exp_sd;
    logic [5:0]  op, fn;
    int          rs, rt, rd, base;
    bit          ewb, est;
    logic [4:0]  ewa;
    string       tag, ptag;
    logic [5:0]  fl [5];
    fl[0] = 6'b100000; fl[1] = 6'b100010; fl[2] = 6'b100100; fl[3] = 6'b100101; fl[4] = 6'b101010;

    // data image with signed corners
    seed = 32'h1234_5678;
    for (int k = 0; k < DD; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      dinit[k] = seed;
    end
    dinit[0] = 32'h7FFF_FFFF; dinit[1] = 32'h8000_0000; dinit[2] = 32'hFFFF_FFFF;
    dinit[3] = 32'h0000_0001; dinit[4] = 32'h0000_0000; dinit[30] = 32'd128;

    for (int k = 0; k < ID; k++) prog[k] = 32'h0;
    // load r1..r14 from words 0..13, r15 from word 30 (value 128)
    for (int k = 1; k < 15; k++) emit(enc_i(6'b100011, 0, k, 16'(4 * (k - 1))));
    emit(enc_i(6'b100011, 0, 15, 16'd120));
    // R3 sweep over every function code and many operand pairs
    for (int f = 0; f < 5; f++)
      for (int i = 0; i < 24; i++) begin
        rs = 1 + (i % 15);
        rt = (i == 5) ? rs : 1 + ((i * 4 + f + 2) % 15);
        rd = 16 + ((i + f) % 15);
        emit(enc_r(rs, rt, rd, fl[f]));
      end
    // R4 undefined function codes
    emit(enc_r(1, 2, 20, 6'h21));
    emit(enc_r(3, 4, 21, 6'h00));
    // R9 writes to register 0, then read it back
    emit(enc_r(1, 4, 0, 6'b100000));
    emit(enc_r(0, 0, 21, 6'b100101));
    emit(enc_r(0, 1, 22, 6'b100000));
    // R10 unknown opcodes
    emit(enc_i(6'h08, 1, 7, 16'd5));
    emit(enc_i(6'h0F, 2, 8, 16'hFFFF));
    emit(enc_i(6'h3F, 3, 9, 16'd0));
    // R6 stores, then R5/R11 loads of the stored words, negative offset
    for (int k = 0; k < 5; k++) emit(enc_i(6'b101011, 0, 16 + k, 16'(4 * (20 + k))));
    emit(enc_i(6'b101011, 15, 3, 16'hFFF8));
    emit(enc_i(6'b100011, 0, 23, 16'd80));
    emit(enc_i(6'b100011, 15, 24, 16'hFFF8));
    emit(enc_i(6'b100011, 0, 25, 16'd92));
    // R7 branch not taken, taken forward, taken backward
    emit(enc_i(6'b000100, 1, 2, 16'd1));
    emit(enc_i(6'b000100, 5, 0, 16'd1));
    emit(enc_r(1, 1, 26, 6'b100000));
    base = n;
    emit(enc_j(base + 2));
    emit(enc_j(base + 3));
    emit(enc_i(6'b000100, 1, 1, 16'hFFFE));
    // R8 forward jump over a write, then park
    base = n;
    emit(enc_j(base + 2));
    emit(enc_r(2, 2, 27, 6'b100000));
    emit(enc_r(26, 27, 28, 6'b100101));
    emit(enc_j(n));

    // R12 preload both memories while in reset
    for (int k = 0; k < ID; k++) begin
      @(negedge clk); pre_we = 1; pre_sel = 0; pre_addr = 8'(k); pre_data = prog[k];
    end
    for (int k = 0; k < DD; k++) begin
      @(negedge clk); pre_we = 1; pre_sel = 1; pre_addr = 8'(k); pre_data = dinit[k];
    end
    @(negedge clk); pre_we = 0;
    @(negedge clk); #1;
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "wb_en in reset", {31'd0, wb_en_o}, 32'd0);
    chk("R1", "st_en in reset", {31'd0, st_en_o}, 32'd0);

    for (int k = 0; k < 32; k++) mreg[k] = 32'd0;
    for (int k = 0; k < DD; k++) mdm[k] = dinit[k];
    mpc = 32'd0;

    @(negedge clk); rst = 0;
    for (int c = 0; c < CYCLES; c++) begin
      #1;
      ins = prog[(mpc >> 2) % ID];
      op = ins[31:26]; fn = ins[5:0];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      a = mreg[rs]; b = mreg[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      npc = mpc + 32'd4;
      ewb = 0; est = 0; ewa = '0; exp_wd = '0; exp_sa = '0; exp_sd = '0;
      tag = "R10"; ptag = "R2";
      case (op)
        6'b000000: begin
          ewa = 5'(rd); ewb = 1; tag = (rd == 0) ? "R9" : "R3 R11";
          case (fn)
            6'b100000: exp_wd = a + b;
            6'b100010: exp_wd = a - b;
            6'b100100: exp_wd = a & b;
            6'b100101: exp_wd = a | b;
            6'b101010: exp_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin ewb = 0; tag = "R4"; end
          endcase
        end
        6'b100011: begin
          addr = a + sx; ewb = 1; ewa = 5'(rt);
          exp_wd = mdm[(addr >> 2) % DD]; tag = "R5 R11 R12";
        end
        6'b101011: begin
          addr = a + sx; est = 1; exp_sa = addr; exp_sd = b; tag = "R6";
        end
        6'b000100: begin
          tag = "R7"; ptag = "R7";
          if (a == b) npc = mpc + 32'd4 + (sx << 2);
        end
        6'b000010: begin
          tag = "R8"; ptag = "R8";
          npc = {npc[31:28], ins[25:0], 2'b00};
        end
        default: tag = "R10";
      endcase
      chk(ptag, "pc", pc_o, mpc);
      chk(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, ewb});
      if (ewb) begin
        chk(tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, ewa});
        chk(tag, "wb_data", wb_data_o, exp_wd);
      end
      chk(tag, "st_en", {31'd0, st_en_o}, {31'd0, est});
      if (est) begin
        chk(tag, "st_addr", st_addr_o, exp_sa);
        chk(tag, "st_data", st_data_o, exp_sd);
      end
      if (ewb && ewa != 5'd0) mreg[ewa] = exp_wd;
      if (est) mdm[(exp_sa >> 2) % DD] = exp_sd;
      mpc = npc;
      @(negedge clk);
    end
    finish_run();
  end
endmodule